// File: doc/BRIEF.md
# Calibrated Multichannel DAC Code Bank

This block holds the digital state behind a bank of voltage-output DAC channels. Each channel keeps a raw input code (two of them, A and B, when alternation is enabled), a gain word and an offset word. A shared engine turns these into a corrected code. The corrected code waits in a pending register until a global update strobe copies every channel's pending code into its DAC register on one edge. The analog converters read those DAC registers.

Every write to a channel's input, gain or offset word marks that channel as stale. The engine services stale channels one at a time. Each computation uses a shift-and-add multiply that takes one cycle per data bit. An active-low busy output stays low while any computation is running or waiting. An update strobe that arrives while the bank is busy is held and carried out on the first edge after the bank goes idle. A clear input loads a programmable code into every DAC register. Channels can be grouped into blocks of eight that alternate between their A and B corrected codes on successive updates, which produces square waves.

Top module: `dacbank_top`

## Requirements
- R1: After a synchronous active-low reset, every DAC code is 0 and `busy_n` is high. Each channel's input words are 0, its gain word is 0x3FFE and its offset word is 0x2000, so the correction starts as an identity. Alternation is off in every group and the clear code is 0.
- R2: `wr_sel` picks the target of a write. 2'b11 selects the channel input word, 2'b10 the offset word, 2'b01 the gain word and 2'b00 a special register chosen by `wr_addr`. Channel writes to addresses at or above the channel count, and special-register writes to any address other than 2 or 12, change nothing and do not make the bank busy.
- R3: The corrected code is floor(x × (g + 2) / 2^14) + c − 2^13, where x is the input word, g the gain word and c the offset word. Results below 0 give 0 and results above 16383 give 16383.
- R4: `busy_n` goes low on the edge that accepts an input, gain or offset write. It stays low until every stale computation has finished. One computation takes 16 cycles when it starts in an idle bank. A write accepted while the bank is busy is queued and never lost.
- R5: The DAC codes change only on an update or a clear. An update copies the pending codes of all channels on the same edge.
- R6: An update strobe seen while `busy_n` is low is held. It is carried out on the first edge at which the bank is idle.
- R7: Special register 2 holds the clear code. A high `clr` loads the clear code into every DAC register on that edge. It takes precedence over an update on the same edge, which is then deferred to the next idle edge.
- R8: Special register 12, bits 6 down to 2, enables alternation: bit 2+k covers channels 8k to 8k+7. On an enabled channel, successive updates output the A code, then the B code, then A again, starting from A. A disabled channel always outputs its A code.
- R9: A write to an input B word (`wr_b` high) is ignored when alternation is off for that channel. The B word keeps its old value and no computation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Write target select |
| wr_addr | input | 6 | Channel number or special register address |
| wr_b | input | 1 | Selects the B input word on input writes |
| wr_data | input | 14 | Write data, bit 13 most significant |
| ld_req | input | 1 | Global update strobe |
| clr | input | 1 | Load the clear code into all DAC registers |
| busy_n | output | 1 | Low while corrections are outstanding |
| dac_codes | output | 560 | DAC register of channel i at bits 14i+13 down to 14i |

## Verification
The bench builds the block with its defaults: 40 channels, 14-bit codes and alternation groups of eight. At these values the last channel (39) and the first illegal addresses (40 to 63) lie inside the 6-bit address space, so both can be tested. The 14-cycle multiply shows up as an exact 16-cycle busy window. With 14-bit codes, gain and offset values can be chosen to drive the result past both clamp limits. Five groups map onto control bits 6 down to 2, so enabling groups 1 and 2 exercises channels 9 and 17 while channel 1 stays unaffected.

// File: rtl/dacbank_pkg.sv
// Package: shared encodings for the DAC code bank.
// Assumes a 6-bit special-register address space.
package dacbank_pkg;

    typedef enum logic [1:0] {
        SEL_SFR   = 2'b00,
        SEL_GAIN  = 2'b01,
        SEL_OFFS  = 2'b10,
        SEL_INPUT = 2'b11
    } regsel_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MUL  = 2'd1,
        ENG_FIN  = 2'd2
    } eng_state_t;

    localparam int SFR_CLRCODE = 2;
    localparam int SFR_CTRL    = 12;
    localparam int TOG_LSB     = 2;

endpackage

// File: rtl/dacbank_mul.sv
// Module: shift-and-add multiplier, one multiplier bit per step.
// Assumes load and step are never high together. After DW steps,
// prod_hi holds the upper DW bits of the 2*DW-bit product.
module dacbank_mul #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] mplier,
    input  logic [DW:0]   mcand,
    output logic [DW-1:0] prod_hi
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] acc;
    logic [PW-1:0] mc;
    logic [DW-1:0] mp;

    // Accumulate the shifted multiplicand for each set multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            mc  <= '0;
            mp  <= '0;
        end else if (load) begin
            acc <= '0;
            mc  <= {{(PW-DW-1){1'b0}}, mcand};
            mp  <= mplier;
        end else if (step) begin
            if (mp[0]) acc <= acc + mc;
            mc <= mc << 1;
            mp <= mp >> 1;
        end
    end

    assign prod_hi = acc[PW-1:DW];
endmodule

// File: rtl/dacbank_engine.sv
// Module: stale-slot tracker and correction sequencer.
// A slot is channel*2+side. The lowest stale slot is served first.
// The store supplies the operands of the picked slot combinationally.
// Each computation: 1 start cycle, DW multiply steps, 1 finish cycle.
module dacbank_engine
    import dacbank_pkg::*;
#(
    parameter int NCH = 40,
    parameter int DW  = 14,
    parameter int CW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark_en,
    input  logic [CW-1:0] mark_ch,
    input  logic          mark_a,
    input  logic          mark_b,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] m_in,
    input  logic [DW-1:0] c_in,
    output logic [CW-1:0] op_ch,
    output logic          op_side,
    output logic          busy,
    output logic          pw_en,
    output logic [CW-1:0] pw_ch,
    output logic          pw_side,
    output logic [DW-1:0] pw_code
);
    localparam int NSLOT  = 2 * NCH;
    localparam int SW     = $clog2(NSLOT);
    localparam int CNTW   = $clog2(DW + 1);
    localparam int HALF_I = 1 << (DW - 1);

    eng_state_t       st;
    logic [CNTW-1:0]  cnt;
    logic [SW-1:0]    idx_q;
    logic [DW-1:0]    c_q;
    logic [NSLOT-1:0] dirty;
    logic [NSLOT-1:0] set_mask;
    logic [NSLOT-1:0] clr_mask;
    logic [SW-1:0]    pick;
    logic             start;
    logic [DW-1:0]    prod_hi;
    logic signed [DW+1:0] sum;

    // Lowest-index stale slot.
    always_comb begin
        pick = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (dirty[i]) pick = SW'(i);
        end
    end

    assign start   = (st == ENG_IDLE) && (|dirty);
    assign op_ch   = CW'(pick >> 1);
    assign op_side = pick[0];

    // Slots set by this cycle's write and cleared by this cycle's start.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int i = 0; i < NCH; i++) begin
            if (mark_en && (mark_ch == CW'(i))) begin
                set_mask[2*i]   = mark_a;
                set_mask[2*i+1] = mark_b;
            end
        end
        if (start) clr_mask[pick] = 1'b1;
    end

    // Stale flags: a new write wins over a start on the same slot.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty <= '0;
        else        dirty <= (dirty & ~clr_mask) | set_mask;
    end

    // Sequencer: idle, multiply for DW steps, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ENG_IDLE;
            cnt   <= '0;
            idx_q <= '0;
            c_q   <= '0;
        end else begin
            case (st)
                ENG_IDLE: if (start) begin
                    st    <= ENG_MUL;
                    cnt   <= '0;
                    idx_q <= pick;
                    c_q   <= c_in;
                end
                ENG_MUL: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNTW'(DW - 1)) st <= ENG_FIN;
                end
                ENG_FIN: st <= ENG_IDLE;
                default: st <= ENG_IDLE;
            endcase
        end
    end

    dacbank_mul #(.DW(DW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .step    (st == ENG_MUL),
        .mplier  (x_in),
        .mcand   ({1'b0, m_in} + (DW+1)'(2)),
        .prod_hi (prod_hi)
    );

    // Add the offset, remove the mid-scale bias, clamp to the code range.
    always_comb begin
        sum = $signed({2'b00, prod_hi}) + $signed({2'b00, c_q})
              - $signed((DW+2)'(HALF_I));
        if (sum[DW+1])  pw_code = '0;
        else if (sum[DW]) pw_code = '1;
        else            pw_code = sum[DW-1:0];
    end

    assign pw_en   = (st == ENG_FIN);
    assign pw_ch   = CW'(idx_q >> 1);
    assign pw_side = idx_q[0];
    assign busy    = (st != ENG_IDLE) || (|dirty);

    // The step counter never passes the data width.
    p_mul_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_MUL) |-> (cnt < CNTW'(DW)));

    // The write-back cycle is always followed by idle.
    p_fin_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_FIN) |=> (st == ENG_IDLE));

    // An accepted write leaves the bank busy on the next cycle.
    p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && (mark_a || mark_b)) |=> busy);
endmodule

// File: rtl/dacbank_store.sv
// Module: per-channel input, calibration, pending and DAC registers.
// Assumes wr_ch, op_ch and pw_ch are below NCH. Only one of the write
// enables is high in a cycle. The clear has priority over an update.
module dacbank_store #(
    parameter int NCH = 40,
    parameter int DW  = 14,
    parameter int CW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     wr_ch,
    input  logic [DW-1:0]     wr_data,
    input  logic              in_we,
    input  logic              in_side,
    input  logic              gain_we,
    input  logic              offs_we,
    input  logic [CW-1:0]     op_ch,
    input  logic              op_side,
    output logic [DW-1:0]     x_out,
    output logic [DW-1:0]     m_out,
    output logic [DW-1:0]     c_out,
    input  logic              pw_en,
    input  logic [CW-1:0]     pw_ch,
    input  logic              pw_side,
    input  logic [DW-1:0]     pw_code,
    input  logic              load_fire,
    input  logic              clr_fire,
    input  logic [DW-1:0]     clr_code,
    input  logic [NCH-1:0]    tog_ch,
    output logic [NCH*DW-1:0] dac_flat
);
    localparam logic [DW-1:0] GAIN_RST = {{(DW-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0] OFFS_RST = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0]  in_a   [NCH];
    logic [DW-1:0]  in_b   [NCH];
    logic [DW-1:0]  gain   [NCH];
    logic [DW-1:0]  offs   [NCH];
    logic [DW-1:0]  pend_a [NCH];
    logic [DW-1:0]  pend_b [NCH];
    logic [DW-1:0]  dac_q  [NCH];
    logic [NCH-1:0] side;

    // Host writes to input and calibration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                in_a[i] <= '0;
                in_b[i] <= '0;
                gain[i] <= GAIN_RST;
                offs[i] <= OFFS_RST;
            end
        end else begin
            if (in_we && !in_side) in_a[wr_ch] <= wr_data;
            if (in_we && in_side)  in_b[wr_ch] <= wr_data;
            if (gain_we)           gain[wr_ch] <= wr_data;
            if (offs_we)           offs[wr_ch] <= wr_data;
        end
    end

    // Operands for the engine's chosen slot.
    assign x_out = op_side ? in_b[op_ch] : in_a[op_ch];
    assign m_out = gain[op_ch];
    assign c_out = offs[op_ch];

    // Engine write-back into the pending codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                pend_a[i] <= '0;
                pend_b[i] <= '0;
            end
        end else if (pw_en) begin
            if (pw_side) pend_b[pw_ch] <= pw_code;
            else         pend_a[pw_ch] <= pw_code;
        end
    end

    // DAC registers: clear, or update with optional A/B alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) dac_q[i] <= '0;
            side <= '0;
        end else if (clr_fire) begin
            for (int i = 0; i < NCH; i++) dac_q[i] <= clr_code;
        end else if (load_fire) begin
            for (int i = 0; i < NCH; i++) begin
                dac_q[i] <= (tog_ch[i] && side[i]) ? pend_b[i] : pend_a[i];
                side[i]  <= tog_ch[i] ? ~side[i] : 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign dac_flat[g*DW +: DW] = dac_q[g];
    end

    // A clear lands the programmed code in the DAC registers.
    p_clear_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (dac_q[0] == $past(clr_code)) && (dac_q[NCH-1] == $past(clr_code)));
endmodule

// File: rtl/dacbank_top.sv
// Module: top of the calibrated DAC code bank.
// Decodes writes, keeps the special registers (clear code and group
// alternation enables), and holds an update strobe while busy.
// Assumes at most one write per cycle.
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NCH = 40,
    parameter int DW  = 14,
    parameter int AW  = 6,
    parameter int GRP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_b,
    input  logic [DW-1:0]     wr_data,
    input  logic              ld_req,
    input  logic              clr,
    output logic              busy_n,
    output logic [NCH*DW-1:0] dac_codes
);
    localparam int CW   = $clog2(NCH);
    localparam int NGRP = (NCH + GRP - 1) / GRP;

    regsel_t         sel;
    logic            ch_ok;
    logic [CW-1:0]   wr_ch;
    logic [NGRP-1:0] tog_q;
    logic [NCH-1:0]  tog_ch;
    logic [DW-1:0]   clr_code_q;
    logic            wr_tog;
    logic            in_we, gain_we, offs_we;
    logic            hold_q, load_fire, busy;
    logic [CW-1:0]   op_ch, pw_ch;
    logic            op_side, pw_en, pw_side;
    logic [DW-1:0]   x_v, m_v, c_v, pw_code;

    assign sel   = regsel_t'(wr_sel);
    assign ch_ok = int'(wr_addr) < NCH;
    assign wr_ch = CW'(wr_addr);

    for (genvar g = 0; g < NCH; g++) begin : g_tog
        assign tog_ch[g] = tog_q[g / GRP];
    end

    // Alternation enable of the addressed channel.
    always_comb begin
        wr_tog = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (wr_addr == AW'(i)) wr_tog = tog_ch[i];
        end
    end

    assign in_we   = wr_en && ch_ok && (sel == SEL_INPUT) && (!wr_b || wr_tog);
    assign gain_we = wr_en && ch_ok && (sel == SEL_GAIN);
    assign offs_we = wr_en && ch_ok && (sel == SEL_OFFS);

    // Special registers: clear code and group alternation enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q      <= '0;
            clr_code_q <= '0;
        end else if (wr_en && (sel == SEL_SFR)) begin
            if (int'(wr_addr) == SFR_CTRL)    tog_q      <= wr_data[TOG_LSB +: NGRP];
            if (int'(wr_addr) == SFR_CLRCODE) clr_code_q <= wr_data;
        end
    end

    assign load_fire = (ld_req || hold_q) && !busy && !clr;

    // Hold an update strobe until the bank is idle and no clear is active.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (clr)       hold_q <= hold_q || ld_req;
        else if (load_fire) hold_q <= 1'b0;
        else if (ld_req)    hold_q <= 1'b1;
    end

    dacbank_engine #(.NCH(NCH), .DW(DW), .CW(CW)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark_en (in_we || gain_we || offs_we),
        .mark_ch (wr_ch),
        .mark_a  (gain_we || offs_we || (in_we && !wr_b)),
        .mark_b  (gain_we || offs_we || (in_we && wr_b)),
        .x_in    (x_v),
        .m_in    (m_v),
        .c_in    (c_v),
        .op_ch   (op_ch),
        .op_side (op_side),
        .busy    (busy),
        .pw_en   (pw_en),
        .pw_ch   (pw_ch),
        .pw_side (pw_side),
        .pw_code (pw_code)
    );

    dacbank_store #(.NCH(NCH), .DW(DW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .in_we     (in_we),
        .in_side   (wr_b),
        .gain_we   (gain_we),
        .offs_we   (offs_we),
        .op_ch     (op_ch),
        .op_side   (op_side),
        .x_out     (x_v),
        .m_out     (m_v),
        .c_out     (c_v),
        .pw_en     (pw_en),
        .pw_ch     (pw_ch),
        .pw_side   (pw_side),
        .pw_code   (pw_code),
        .load_fire (load_fire),
        .clr_fire  (clr),
        .clr_code  (clr_code_q),
        .tog_ch    (tog_ch),
        .dac_flat  (dac_codes)
    );

    assign busy_n = !busy;

    // DAC codes only move on an update or a clear.
    p_dac_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && !clr) |=> $stable(dac_codes));

    // A held strobe is consumed on the first idle edge without a clear.
    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !busy && !clr) |=> !hold_q);
endmodule

// File: tb/dacbank_top_test.sv
`timescale 1ns/1ps
module dacbank_top_test;
    localparam int NCH = 40;
    localparam int DW  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [5:0] wr_addr = '0;
    logic wr_b = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic ld_req = 1'b0;
    logic clr = 1'b0;
    logic busy_n;
    logic [NCH*DW-1:0] dac_codes;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dacbank_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_b(wr_b), .wr_data(wr_data),
        .ld_req(ld_req), .clr(clr), .busy_n(busy_n), .dac_codes(dac_codes)
    );

    function automatic int dac(int ch);
        return int'(dac_codes[ch*DW +: DW]);
    endfunction

    function automatic int corr(int x, int g, int c);
        int r;
        r = ((x * (g + 2)) >>> 14) + c - 8192;
        if (r < 0) r = 0;
        if (r > 16383) r = 16383;
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int mA[NCH], mB[NCH], mG[NCH], mC[NCH], pA[NCH], pB[NCH], mD[NCH];
    bit mS[NCH];
    bit dty[2*NCH];
    int ecnt, eidx, ex, eg, ec, mtog, mclr;
    bit mhold;

    function automatic bit any_dirty();
        foreach (dty[i]) if (dty[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit tog_on(int ch);
        return ((mtog >> (ch / 8)) & 1) != 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mA[i] = 0; mB[i] = 0; mG[i] = 16382; mC[i] = 8192;
                pA[i] = 0; pB[i] = 0; mD[i] = 0; mS[i] = 0;
            end
            foreach (dty[i]) dty[i] = 0;
            ecnt = 0; eidx = 0; ex = 0; eg = 0; ec = 0;
            mtog = 0; mclr = 0; mhold = 0;
        end else begin
            bit bz, fire;
            bz = (ecnt != 0) || any_dirty();
            fire = (ld_req || mhold) && !bz && !clr;
            if (ecnt == 0) begin
                if (any_dirty()) begin
                    for (int i = 2*NCH - 1; i >= 0; i--) if (dty[i]) eidx = i;
                    ex = (eidx % 2 == 1) ? mB[eidx/2] : mA[eidx/2];
                    eg = mG[eidx/2];
                    ec = mC[eidx/2];
                    dty[eidx] = 0;
                    ecnt = 1;
                end
            end else if (ecnt < 15) begin
                ecnt++;
            end else begin
                if (eidx % 2 == 1) pB[eidx/2] = corr(ex, eg, ec);
                else               pA[eidx/2] = corr(ex, eg, ec);
                ecnt = 0;
            end
            if (clr) begin
                for (int i = 0; i < NCH; i++) mD[i] = mclr;
            end else if (fire) begin
                for (int i = 0; i < NCH; i++) begin
                    mD[i] = (tog_on(i) && mS[i]) ? pB[i] : pA[i];
                    mS[i] = tog_on(i) ? !mS[i] : 1'b0;
                end
            end
            if (clr)       mhold = mhold || ld_req;
            else if (fire) mhold = 0;
            else if (ld_req) mhold = 1;
            if (wr_en) begin
                int a;
                a = int'(wr_addr);
                if (wr_sel == 2'b00) begin
                    if (a == 2)  mclr = int'(wr_data);
                    if (a == 12) mtog = (int'(wr_data) >> 2) & 31;
                end else if (a < NCH) begin
                    if (wr_sel == 2'b11) begin
                        if (!wr_b) begin mA[a] = int'(wr_data); dty[2*a] = 1; end
                        else if (tog_on(a)) begin mB[a] = int'(wr_data); dty[2*a+1] = 1; end
                    end else begin
                        if (wr_sel == 2'b01) mG[a] = int'(wr_data);
                        else                 mC[a] = int'(wr_data);
                        dty[2*a] = 1; dty[2*a+1] = 1;
                    end
                end
            end
        end
    end

    // Every-cycle comparison against the model (R4 busy, R5 codes).
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int bad;
            bit exp_bn;
            bad = -1;
            exp_bn = !((ecnt != 0) || any_dirty());
            check(busy_n == exp_bn, "R4 busy_n vs model", int'(busy_n), int'(exp_bn));
            for (int i = NCH - 1; i >= 0; i--) if (dac(i) != mD[i]) bad = i;
            if (bad >= 0) check(1'b0, "R5 dac code vs model", dac(bad), mD[bad]);
            else          check(1'b1, "R5", 0, 0);
        end
    end

    task automatic wr(input logic [1:0] s, input int a, input bit b, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = 6'(a); wr_b = b; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_n == 1'b0) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic update();
        @(negedge clk);
        ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dac(0) == 0 && dac(39) == 0, "R1 reset dac", dac(39), 0);
        check(busy_n == 1'b1, "R1 reset busy_n", int'(busy_n), 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R5: update with no writes keeps code 0
        update();
        check(dac(0) == 0, "R5 empty update", dac(0), 0);

        // R4/R3: single write, identity correction
        wr(2'b11, 5, 0, 1234);
        wait_idle(n);
        check(n == 16, "R4 busy window", n, 16);
        check(dac(5) == 0, "R5 no update yet", dac(5), 0);
        update();
        check(dac(5) == 1234, "R3 identity", dac(5), 1234);

        // R3: half gain
        wr(2'b01, 5, 0, 16'h1FFE);
        wait_idle(n);
        update();
        check(dac(5) == 617, "R3 half gain", dac(5), 617);

        // R3: upper clamp
        wr(2'b01, 5, 0, 16'h3FFE);
        wr(2'b10, 5, 0, 16'h3FFF);
        wr(2'b11, 5, 0, 16383);
        wait_idle(n);
        update();
        check(dac(5) == 16383, "R3 upper clamp", dac(5), 16383);

        // R3: lower clamp and a plain offset on the last channel
        wr(2'b10, 5, 0, 0);
        wr(2'b11, 5, 0, 100);
        wr(2'b10, 39, 0, 16'h2100);
        wr(2'b11, 39, 0, 10);
        wait_idle(n);
        update();
        check(dac(5) == 0, "R3 lower clamp", dac(5), 0);
        check(dac(39) == corr(10, 16382, 8448), "R3 offset ch39", dac(39), 266);

        // R4: back-to-back writes are both computed
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'b11; wr_addr = 6'd3; wr_b = 1'b0; wr_data = 14'd50;
        @(negedge clk);
        wr_addr = 6'd1; wr_data = 14'd60;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle(n);
        check(n == 31, "R4 queued busy window", n, 31);
        update();
        check(dac(3) == 50, "R4 first queued", dac(3), 50);
        check(dac(1) == 60, "R4 second queued", dac(1), 60);

        // R6: update during busy is held
        wr(2'b11, 4, 0, 222);
        update();
        check(dac(4) == 0, "R6 held while busy", dac(4), 0);
        wait_idle(n);
        check(dac(4) == 0, "R6 not before idle edge", dac(4), 0);
        @(negedge clk);
        check(dac(4) == 222, "R6 released", dac(4), 222);

        // R7: clear overrides a same-cycle update, which follows next
        wr(2'b00, 2, 0, 16'h0ABC);
        @(negedge clk);
        clr = 1'b1; ld_req = 1'b1;
        @(negedge clk);
        clr = 1'b0; ld_req = 1'b0;
        check(dac(0) == 16'h0ABC && dac(39) == 16'h0ABC, "R7 clear code", dac(39), 16'h0ABC);
        @(negedge clk);
        check(dac(1) == 60, "R7 deferred update", dac(1), 60);

        // R2: illegal channel and unused special address are ignored
        wr(2'b11, 45, 0, 999);
        check(busy_n == 1'b1, "R2 addr 45 ignored", int'(busy_n), 1);
        wr(2'b00, 7, 0, 16'h3FFF);
        check(busy_n == 1'b1, "R2 sfr 7 ignored", int'(busy_n), 1);
        update();
        check(dac(1) == 60 && dac(5) == 0, "R2 codes unchanged", dac(1), 60);

        // R9: B write with alternation off
        wr(2'b11, 17, 1, 777);
        check(busy_n == 1'b1, "R9 B write ignored", int'(busy_n), 1);

        // R8: alternation on groups 1 and 2 (control bits 3 and 4)
        wr(2'b00, 12, 0, (1 << 3) | (1 << 4));
        wr(2'b11, 9, 1, 500);
        wr(2'b11, 9, 0, 300);
        wr(2'b11, 17, 0, 40);
        wait_idle(n);
        update();
        check(dac(9) == 300, "R8 first A", dac(9), 300);
        check(dac(17) == 40, "R8 ch17 A", dac(17), 40);
        update();
        check(dac(9) == 500, "R8 then B", dac(9), 500);
        check(dac(17) == 0, "R9 B kept reset value", dac(17), 0);
        check(dac(1) == 60, "R8 disabled group stays A", dac(1), 60);
        update();
        check(dac(9) == 300, "R8 back to A", dac(9), 300);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule